// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits in front of a small processor core and turns five hardware request lines into one prioritized interrupt decision. The lines are a non-maskable line (`trap_in`) and four maskable lines: `rst75_in`, `rst65_in`, `rst55_in` and `intr_in`. Each line has its own trigger style. The non-maskable line needs a rising edge and must then stay high. `rst75_in` is edge-captured into a latch. The other three lines are plain levels.

The block combines the requests with a three-bit mask and a global enable. It reports a pending flag together with the 16-bit vector of the winning line. When the winner is `intr_in`, there is no internal vector, and the block sets a flag saying the vector must come from outside. The core signals an instruction boundary with `boundary`. On that strobe the block accepts the winner and answers, one clock later, with a one-cycle `take` pulse that carries the captured vector. Pushing the program counter and fetching the external opcode belong to the core and are not part of this block.

A separate combinational helper maps a software restart number n (0 to 7) to the vector n × 8.

Top module: `irq_prio_ctl`

## Requirements
- R1: Priority is fixed, highest first: trap, rst75, rst65, rst55, intr. `pend` is high when at least one request is eligible, and the vector outputs always describe the highest eligible request.
- R2: The vectors are: trap 16'h0024, rst75 16'h003C, rst65 16'h0034, rst55 16'h002C. When intr wins, `vec_addr` is 16'h0000 and `vec_ext` is 1. In every other case `vec_ext` is 0.
- R3: Trap ignores both the mask and the global enable. It becomes eligible one clock after a sampled 0-to-1 transition and stays eligible only while `trap_in` is high. After it is accepted, or after a reset with `trap_in` held high, it needs the input to go low and then high again.
- R4: A 0-to-1 transition on `rst75_in` sets a latch that stays set after the input drops. The latch clears when rst75 is accepted, or on a mask write with `msk_clr75` = 1. A new edge in the same clock takes precedence over the clear. The latch captures edges even while masked.
- R5: rst65, rst55 and intr follow their input levels with no latching. A request that drops before acceptance is lost.
- R6: The maskable lines are eligible only while the global enable is 1. `en_cmd` sets the enable and `dis_cmd` clears it; `dis_cmd` wins if both are high. A mask write (`msk_wr`) loads `msk_val`. Mask bit 0 masks rst55, bit 1 masks rst65 and bit 2 masks rst75; a mask bit of 1 blocks its line. The mask never affects intr.
- R7: A request is accepted only in a clock where `boundary` and `pend` are both high. In the next cycle `take` is high for one cycle, and `take_vec` and `take_ext` hold the vector and the external flag captured at acceptance. `take_vec` and `take_ext` keep those values until the next acceptance.
- R8: `inta_n` goes low for exactly the one cycle that follows acceptance of intr. It is high at all other times.
- R9: Any acceptance clears the global enable, and this takes precedence over `en_cmd` in the same clock.
- R10: `sw_vec` equals `sw_num` × 8, zero-extended to 16 bits.
- R11: While `rst_n` is low, the global enable is 0, the mask is 3'b111, both latches are clear, `take` is 0 and `inta_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_in | input | 1 | Non-maskable request, edge and level |
| rst75_in | input | 1 | Edge-latched maskable request |
| rst65_in | input | 1 | Level maskable request |
| rst55_in | input | 1 | Level maskable request |
| intr_in | input | 1 | Level request with external vector |
| boundary | input | 1 | Instruction-complete strobe |
| en_cmd | input | 1 | Set global enable |
| dis_cmd | input | 1 | Clear global enable |
| msk_wr | input | 1 | Mask write strobe |
| msk_val | input | 3 | New mask bits (bit0 rst55, bit1 rst65, bit2 rst75) |
| msk_clr75 | input | 1 | With msk_wr, clear the rst75 latch |
| sw_num | input | 3 | Software restart number |
| sw_vec | output | 16 | Software restart vector |
| pend | output | 1 | An eligible request exists |
| vec_addr | output | 16 | Vector of the current winner |
| vec_ext | output | 1 | Winner is intr (external vector) |
| take | output | 1 | One-cycle acceptance pulse |
| take_vec | output | 16 | Vector captured at acceptance |
| take_ext | output | 1 | External flag captured at acceptance |
| inta_n | output | 1 | Active-low intr acknowledge |

## Verification
The sequences below are checked against a cycle-level model on every clock.

- **Priority:** several lines are raised together, then released one by one. This shows whether the priority chain and the vector table are right.
- **rst75 pulse:** a one-cycle pulse on `rst75_in` separates the latched line from the level lines. A mask write with the clear bit separates latch clearing from plain masking.
- **Trap:** trap is driven high, dropped, raised again, and held high through acceptance and through reset. This shows whether edge qualification, the level hold and re-arming are right.
- **Enable races:** `en_cmd` and `dis_cmd` are raised together, and `en_cmd` is raised in the same clock as an acceptance. These expose which command has precedence.

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trap_in,
  input  logic          rst75_in,
  input  logic          rst65_in,
  input  logic          rst55_in,
  input  logic          intr_in,
  input  logic          boundary,
  input  logic          en_cmd,
  input  logic          dis_cmd,
  input  logic          msk_wr,
  input  logic [2:0]    msk_val,
  input  logic          msk_clr75,
  input  logic [2:0]    sw_num,
  output logic [AW-1:0] sw_vec,
  output logic          pend,
  output logic [AW-1:0] vec_addr,
  output logic          vec_ext,
  output logic          take,
  output logic [AW-1:0] take_vec,
  output logic          take_ext,
  output logic          inta_n
);
  localparam logic [AW-1:0] V_TRAP = AW'(16'h0024);
  localparam logic [AW-1:0] V_R75  = AW'(16'h003C);
  localparam logic [AW-1:0] V_R65  = AW'(16'h0034);
  localparam logic [AW-1:0] V_R55  = AW'(16'h002C);

  logic       trap_q, trap_hit, r75_q, r75_hit, ie;
  logic [2:0] mask;

  wire trap_req = trap_hit & trap_in;
  wire r75_req  = r75_hit & ~mask[2];
  wire r65_req  = rst65_in & ~mask[1];
  wire r55_req  = rst55_in & ~mask[0];
  wire win75    = ~trap_req & ie & r75_req;
  wire accept   = boundary & pend;

  assign sw_vec = AW'({sw_num, 3'b000});
  assign pend   = trap_req | (ie & (r75_req | r65_req | r55_req | intr_in));

  always_comb begin
    vec_addr = '0;
    vec_ext  = 1'b0;
    if (trap_req)            vec_addr = V_TRAP;
    else if (ie & r75_req)   vec_addr = V_R75;
    else if (ie & r65_req)   vec_addr = V_R65;
    else if (ie & r55_req)   vec_addr = V_R55;
    else if (ie & intr_in)   vec_ext  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_q   <= 1'b1;
      trap_hit <= 1'b0;
      r75_q    <= 1'b0;
      r75_hit  <= 1'b0;
      ie       <= 1'b0;
      mask     <= 3'b111;
      take     <= 1'b0;
      take_vec <= '0;
      take_ext <= 1'b0;
      inta_n   <= 1'b1;
    end else begin
      trap_q <= trap_in;
      if (trap_in & ~trap_q)                    trap_hit <= 1'b1;
      else if (~trap_in | (accept & trap_req))  trap_hit <= 1'b0;

      r75_q <= rst75_in;
      if (rst75_in & ~r75_q)                           r75_hit <= 1'b1;
      else if ((accept & win75) | (msk_wr & msk_clr75)) r75_hit <= 1'b0;

      if (msk_wr) mask <= msk_val;

      if (accept)       ie <= 1'b0;
      else if (dis_cmd) ie <= 1'b0;
      else if (en_cmd)  ie <= 1'b1;

      take   <= accept;
      inta_n <= ~(accept & vec_ext);
      if (accept) begin
        take_vec <= vec_addr;
        take_ext <= vec_ext;
      end
    end
  end

  AST_ONE_SHOT:      assert property (@(posedge clk) disable iff (!rst_n) take |=> !take);                       // R7
  AST_AT_BOUNDARY:   assert property (@(posedge clk) disable iff (!rst_n) take |-> $past(boundary));              // R7
  AST_ENABLE_DROPS:  assert property (@(posedge clk) disable iff (!rst_n) take |-> !ie);                          // R9
  AST_ACK_FOR_EXT:   assert property (@(posedge clk) disable iff (!rst_n) !inta_n |-> (take && take_ext));        // R8
  AST_OFF_ONLY_TRAP: assert property (@(posedge clk) disable iff (!rst_n) (pend && !ie) |-> trap_in);             // R3
  AST_TRAP_LEVEL:    assert property (@(posedge clk) disable iff (!rst_n) (vec_addr == V_TRAP) |-> trap_in);     // R3
endmodule

// File: tb/sim_irq_prio_ctl.sv
module sim_irq_prio_ctl;
  logic clk = 0, rst_n = 0;
  logic trap_in = 0, rst75_in = 0, rst65_in = 0, rst55_in = 0, intr_in = 0;
  logic boundary = 0, en_cmd = 0, dis_cmd = 0, msk_wr = 0, msk_clr75 = 0;
  logic [2:0] msk_val = 0, sw_num = 0;
  logic [15:0] sw_vec, vec_addr, take_vec;
  logic pend, vec_ext, take, take_ext, inta_n;
  int total = 0, bad = 0, cycles = 0;

  always #4 clk = ~clk;

  irq_prio_ctl u0 (.*);

  // reference model state
  bit m_tq = 1, m_th = 0, m_7q = 0, m_7h = 0, m_ie = 0, m_take = 0, m_ext = 0, m_inta = 1;
  bit [2:0] m_mask = 7;
  int m_vec = 0;

  function automatic void model_out(output bit p, output int v, output bit e);
    bit t = m_th && trap_in;
    p = 0; v = 0; e = 0;
    if (t) begin p = 1; v = 'h24; end
    else if (m_ie && m_7h && !m_mask[2]) begin p = 1; v = 'h3C; end
    else if (m_ie && rst65_in && !m_mask[1]) begin p = 1; v = 'h34; end
    else if (m_ie && rst55_in && !m_mask[0]) begin p = 1; v = 'h2C; end
    else if (m_ie && intr_in) begin p = 1; e = 1; end
  endfunction

  always @(posedge clk) begin
    bit p, e, acc; int v;
    if (!rst_n) begin
      m_tq = 1; m_th = 0; m_7q = 0; m_7h = 0; m_ie = 0; m_mask = 7;
      m_take = 0; m_vec = 0; m_ext = 0; m_inta = 1;
    end else begin
      model_out(p, v, e);
      acc = boundary && p;
      if (trap_in && !m_tq) m_th = 1;
      else if (!trap_in || (acc && v == 'h24)) m_th = 0;
      m_tq = trap_in;
      if (rst75_in && !m_7q) m_7h = 1;
      else if ((acc && v == 'h3C) || (msk_wr && msk_clr75)) m_7h = 0;
      m_7q = rst75_in;
      if (msk_wr) m_mask = msk_val;
      if (acc || dis_cmd) m_ie = 0; else if (en_cmd) m_ie = 1;
      m_take = acc; m_inta = !(acc && e);
      if (acc) begin m_vec = v; m_ext = e; end
    end
  end

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic cmp_all();
    bit p, e; int v;
    model_out(p, v, e);
    chk("R1 pend", pend, p);
    chk("R2 vec", vec_addr, v);
    chk("R2 ext", vec_ext, e);
    chk("R7 take", take, m_take);
    chk("R7 take_vec", take_vec, m_vec);
    chk("R7 take_ext", take_ext, m_ext);
    chk("R8 inta", inta_n, m_inta);
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
    cycles++;
    if (rst_n) cmp_all();
  endtask

  always @(posedge clk) if (cycles > 5000) begin
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    chk("R11 pend", pend, 0); chk("R11 take", take, 0); chk("R11 inta", inta_n, 1);
    for (int n = 0; n < 8; n++) begin sw_num = 3'(n); #1; chk("R10 swvec", sw_vec, n * 8); end
    // R6: masked with enable off by reset
    rst55_in = 1; step(); chk("R6 masked", pend, 0);
    en_cmd = 1; msk_wr = 1; msk_val = 0; step(); en_cmd = 0; msk_wr = 0;
    step(); chk("R5 r55 pend", vec_addr, 'h2C);
    boundary = 1; step(); boundary = 0;
    chk("R7 take r55", take_vec, 'h2C);
    step(); chk("R9 ie cleared", pend, 0);
    rst55_in = 0;
    // R1 priority with several lines
    en_cmd = 1; step(); en_cmd = 0;
    intr_in = 1; rst65_in = 1; rst55_in = 1; step(); chk("R1 r65 wins", vec_addr, 'h34);
    rst65_in = 0; step(); chk("R1 r55 wins", vec_addr, 'h2C);
    rst55_in = 0; step(); chk("R2 intr ext", vec_ext, 1);
    boundary = 1; step(); boundary = 0; chk("R8 inta low", inta_n, 0);
    step(); chk("R8 inta back", inta_n, 1);
    intr_in = 0;
    // R4 rst75 latch
    en_cmd = 1; rst75_in = 1; step(); en_cmd = 0; rst75_in = 0; step();
    chk("R4 latched", vec_addr, 'h3C);
    rst55_in = 1; step(); chk("R1 r75 over r55", vec_addr, 'h3C);
    msk_wr = 1; msk_clr75 = 1; msk_val = 0; step(); msk_wr = 0; msk_clr75 = 0;
    chk("R4 cleared", vec_addr, 'h2C);
    rst55_in = 0;
    rst75_in = 1; step(); rst75_in = 0; boundary = 1; step(); boundary = 0;
    chk("R4 accept", take_vec, 'h3C);
    en_cmd = 1; step(); en_cmd = 0; step(); chk("R4 ack clears", pend, 0);
    // R6 mask of rst65, and en/dis race
    msk_wr = 1; msk_val = 3'b010; rst65_in = 1; step(); msk_wr = 0;
    chk("R6 r65 masked", pend, 0);
    msk_wr = 1; msk_val = 0; en_cmd = 1; dis_cmd = 1; step(); msk_wr = 0; en_cmd = 0; dis_cmd = 0;
    chk("R6 dis wins", pend, 0);
    // R9 accept beats en_cmd
    en_cmd = 1; step(); en_cmd = 0; chk("R5 r65 level", vec_addr, 'h34);
    boundary = 1; en_cmd = 1; step(); boundary = 0; en_cmd = 0;
    step(); chk("R9 accept beats en", pend, 0);
    rst65_in = 0;
    // R3 trap
    trap_in = 1; step(); chk("R3 trap ie off", vec_addr, 'h24);
    trap_in = 0; step(); chk("R3 level", pend, 0);
    trap_in = 1; step(); step(); boundary = 1; step(); boundary = 0;
    chk("R3 trap take", take_vec, 'h24);
    step(); step(); chk("R3 no rearm", pend, 0);
    rst_n = 0; step(); rst_n = 1; step(); step(); chk("R3 held thru reset", pend, 0);
    trap_in = 0; step(); trap_in = 1; step(); chk("R3 rearm", pend, 1);
    trap_in = 0; step(); step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule